// File: doc/BRIEF.md
# Coprocessor Two-Word Load/Store Sequencer

This block moves data between a 32-bit memory data bus and a bank of sixteen 64-bit coprocessor registers. Each register holds an upper word and a lower word. A transfer is either short (one bus word) or long (two bus words), and either a load (bus to register) or a store (register to bus). A data-type select marks a short transfer as single-precision float or 32-bit integer, and this decides which half of the register the word uses. A big-endian flag sets the order of the two halves in a long transfer.

A transfer begins when `start` is pulsed while the sequencer is idle. At that moment the command selects and the destination register index are captured. After that, each `dataValid` strobe moves one word. A load takes the word from `busIn`. A store presents its word on `storeData` for the whole time the sequencer waits for that strobe. After the last word the sequencer raises `done` for one cycle and then returns to idle. A read port lets the surrounding logic observe any register at any time. Address generation and bus arbitration belong to the neighbouring logic.

Top module: `cop_xfer_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, `done` is low and `storeData` is zero. After reset every register reads back as zero.
- R2: The register used by a transfer is the one named by instruction bits [15:12] when the transfer was started. No other register changes.
- R3: In a long load with `bigEndian` = 1, the first word goes to the upper half (bits 63:32) and the second word to the lower half (bits 31:0).
- R4: In a long load with `bigEndian` = 0, the first word goes to the lower half and the second word to the upper half.
- R5: A short load with `isFloat` = 1 writes the word into the upper half and leaves the lower half unchanged.
- R6: A short load with `isFloat` = 0 writes the word into the lower half and fills all 32 upper bits with bit 31 of the word.
- R7: A short store sends the upper half when `isFloat` = 1 and the lower half when `isFloat` = 0. `storeData` shows the pending word while the transfer is active and is zero otherwise. A store changes no register.
- R8: A long store sends the halves in the same `bigEndian`-dependent order as a long load: upper then lower when it is 1, lower then upper when it is 0.
- R9: `done` is high for exactly one cycle. That cycle follows the clock edge that accepted the last word, which is the first word of a short transfer and the second word of a long one.
- R10: A `start` pulse while a transfer is active or finishing is ignored. The active transfer keeps its command and register, and no extra transfer follows.
- R11: `dataValid` strobes while idle are ignored. No register changes and `done` stays low.
- R12: Cycles without `dataValid` during a transfer stall it. No word is consumed and `done` stays low until the last word arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a transfer when the sequencer is idle |
| isLoad | input | 1 | 1 = load from bus into register, 0 = store from register to bus |
| isLong | input | 1 | 1 = two-word transfer, 0 = one-word transfer |
| isFloat | input | 1 | Short transfers only: 1 = single float (upper half), 0 = 32-bit integer (lower half) |
| bigEndian | input | 1 | Half order of a long transfer: 1 = upper half first |
| instr | input | 32 | Instruction word; bits [15:12] give the register index |
| dataValid | input | 1 | One word moves on the bus in this cycle |
| busIn | input | 32 | Load data from memory |
| storeData | output | 32 | Store data to memory, valid while a store waits for its strobe |
| done | output | 1 | One-cycle pulse after the last word |
| rdIdx | input | 4 | Register index for the observation port |
| rdData | output | 64 | Contents of register `rdIdx` |

## Verification
The properties assume that `dataValid` is only meaningful during a transfer, and that the read index is held steady when register stability is checked. The checker therefore compares `rdData` only across cycles where `rdIdx` has not changed. The bench drives `start` only as a single-cycle pulse and moves all inputs on the falling edge. The `start` pulses it sends into a busy transfer carry different command fields, so a wrongly accepted start would show as a changed register or an early `done`. Strobe gaps and idle strobes are placed on purpose to exercise the stall and ignore paths.

// File: rtl/cop_xfer_pkg.sv
`timescale 1ns/1ps
package cop_xfer_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int INSTR_W  = 32;
  localparam int DEST_LSB = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             active;     // a transfer is in progress
    logic             wrHi;       // write upper half this cycle
    logic             wrLo;       // write lower half this cycle
    logic             hiSignFill; // upper half takes sign copies
    logic             selHi;      // store word comes from upper half
    logic [IDX_W-1:0] dest;       // target register
  } dpStrobe_t;
endpackage

// File: rtl/cop_xfer_ctrl.sv
`timescale 1ns/1ps
module cop_xfer_ctrl
  import cop_xfer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               isLoad,
  input  logic               isLong,
  input  logic               isFloat,
  input  logic               bigEndian,
  input  logic [INSTR_W-1:0] instr,
  input  logic               dataValid,
  output dpStrobe_t          strobe,
  output logic               done,
  output logic               busy
);
  seqState_t        state;
  logic             opLoad, opLong, opFloat, opBig;
  logic [IDX_W-1:0] opDest;
  logic             wordIdx;
  logic             lastWord, hiSlot, beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      opLoad  <= 1'b0;
      opLong  <= 1'b0;
      opFloat <= 1'b0;
      opBig   <= 1'b0;
      opDest  <= '0;
      wordIdx <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            opLoad  <= isLoad;
            opLong  <= isLong;
            opFloat <= isFloat;
            opBig   <= bigEndian;
            opDest  <= instr[DEST_LSB +: IDX_W];
            wordIdx <= 1'b0;
            state   <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (dataValid) begin
            if (lastWord) state <= ST_FIN;
            else          wordIdx <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state == ST_BUSY);
    done     = (state == ST_FIN);
    lastWord = !opLong || wordIdx;
    // long: big-endian puts word 0 high; short: float lives high
    hiSlot   = opLong ? (opBig ^ wordIdx) : opFloat;
    beat     = busy && dataValid && opLoad;

    strobe.active     = busy;
    strobe.hiSignFill = !opLong && !opFloat;
    strobe.wrHi       = beat && (hiSlot || strobe.hiSignFill);
    strobe.wrLo       = beat && !hiSlot;
    strobe.selHi      = hiSlot;
    strobe.dest       = opDest;
  end
endmodule

// File: rtl/cop_xfer_dp.sv
`timescale 1ns/1ps
module cop_xfer_dp
  import cop_xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic [WORD_W-1:0]   busIn,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [WORD_W-1:0]   storeData,
  output logic [2*WORD_W-1:0] rdData
);
  localparam int REG_W = 2 * WORD_W;

  logic [REG_W-1:0]  bank [NUM_REGS];
  logic [WORD_W-1:0] hiNext;
  logic [REG_W-1:0]  destReg;

  always_comb begin
    hiNext  = strobe.hiSignFill ? {WORD_W{busIn[WORD_W-1]}} : busIn;
    destReg = bank[strobe.dest];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      if (strobe.wrHi) bank[strobe.dest][REG_W-1:WORD_W] <= hiNext;
      if (strobe.wrLo) bank[strobe.dest][WORD_W-1:0]     <= busIn;
    end
  end

  always_comb begin
    if (!strobe.active)   storeData = '0;
    else if (strobe.selHi) storeData = destReg[REG_W-1:WORD_W];
    else                   storeData = destReg[WORD_W-1:0];
    rdData = bank[rdIdx];
  end
endmodule

// File: rtl/cop_xfer_seq.sv
`timescale 1ns/1ps
module cop_xfer_seq
  import cop_xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                isLoad,
  input  logic                isLong,
  input  logic                isFloat,
  input  logic                bigEndian,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                dataValid,
  input  logic [WORD_W-1:0]   busIn,
  output logic [WORD_W-1:0]   storeData,
  output logic                done,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [2*WORD_W-1:0] rdData
);
  dpStrobe_t ctlStrobe;
  logic      seqBusy;

  cop_xfer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .isLoad(isLoad), .isLong(isLong),
    .isFloat(isFloat), .bigEndian(bigEndian), .instr(instr),
    .dataValid(dataValid), .strobe(ctlStrobe), .done(done), .busy(seqBusy)
  );

  cop_xfer_dp u_dp (
    .clk(clk), .rst(rst), .strobe(ctlStrobe), .busIn(busIn), .rdIdx(rdIdx),
    .storeData(storeData), .rdData(rdData)
  );
endmodule

// File: rtl/cop_xfer_chk.sv
`timescale 1ns/1ps
module cop_xfer_chk
  import cop_xfer_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                dataValid,
  input logic                done,
  input logic                busy,
  input logic [WORD_W-1:0]   storeData,
  input logic [IDX_W-1:0]    rdIdx,
  input logic [2*WORD_W-1:0] rdData
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(dataValid) && !busy));

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (!$stable(rdIdx) || $stable(rdData)));

  assert_store_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (storeData == '0));

  assert_stall_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && !dataValid) |=> (busy && !done));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !dataValid) |=> busy);
endmodule

bind cop_xfer_seq cop_xfer_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .dataValid(dataValid), .done(done),
  .busy(seqBusy), .storeData(storeData), .rdIdx(rdIdx), .rdData(rdData)
);

// File: tb/tb_cop_xfer_seq.sv
`timescale 1ns/1ps
module tb_cop_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, isLoad = 1'b0, isLong = 1'b0, isFloat = 1'b0, bigEndian = 1'b0;
  logic [31:0] instr = '0;
  logic        dataValid = 1'b0;
  logic [31:0] busIn = '0;
  logic [31:0] storeData;
  logic        done;
  logic [3:0]  rdIdx = '0;
  logic [63:0] rdData;

  logic [63:0] model [16];
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  cop_xfer_seq dut (
    .clk(clk), .rst(rst), .start(start), .isLoad(isLoad), .isLong(isLong),
    .isFloat(isFloat), .bigEndian(bigEndian), .instr(instr),
    .dataValid(dataValid), .busIn(busIn), .storeData(storeData),
    .done(done), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkReg(input string tag, input int idx);
    rdIdx = idx[3:0];
    #1;
    check(tag, rdData, model[idx]);
  endtask

  task automatic issue(input logic ld, input logic lg, input logic fl,
                       input logic be, input int dest);
    @(negedge clk);
    start = 1'b1; isLoad = ld; isLong = lg; isFloat = fl; bigEndian = be;
    instr = {16'hC3A5, dest[3:0], 12'h5A6};
    @(negedge clk);
    start = 1'b0;
    isLoad = ~ld; isLong = ~lg; isFloat = ~fl; bigEndian = ~be; instr = '0;
  endtask

  task automatic testReset();
    #1;
    check("R1 done after reset", {63'd0, done}, 64'd0);
    check("R1 storeData after reset", {32'd0, storeData}, 64'd0);
    for (int i = 0; i < 16; i++) checkReg("R1 register cleared", i);
  endtask

  task automatic testLoad(input string tag, input logic lg, input logic fl,
                          input logic be, input int dest,
                          input logic [31:0] w0, input logic [31:0] w1);
    issue(1'b1, lg, fl, be, dest);
    dataValid = 1'b1; busIn = w0;
    if (lg) begin
      @(negedge clk);
      #1;
      check({tag, " R9 no done mid-transfer"}, {63'd0, done}, 64'd0);
      busIn = w1;
    end
    @(negedge clk);
    dataValid = 1'b0; busIn = 32'hDEAD_BEEF;
    #1;
    check({tag, " R9 done after last word"}, {63'd0, done}, 64'd1);
    if (lg)      model[dest] = be ? {w0, w1} : {w1, w0};
    else if (fl) model[dest] = {w0, model[dest][31:0]};
    else         model[dest] = {{32{w0[31]}}, w0};
    checkReg({tag, " register contents"}, dest);
    checkReg({tag, " R2 neighbour untouched"}, (dest + 1) % 16);
    @(negedge clk);
    #1;
    check({tag, " R9 done one cycle"}, {63'd0, done}, 64'd0);
  endtask

  task automatic testStore(input string tag, input logic lg, input logic fl,
                           input logic be, input int dest);
    logic [31:0] hi, lo, e0, e1;
    hi = model[dest][63:32];
    lo = model[dest][31:0];
    e0 = lg ? (be ? hi : lo) : (fl ? hi : lo);
    e1 = be ? lo : hi;
    issue(1'b0, lg, fl, be, dest);
    dataValid = 1'b1; busIn = 32'h1234_5678;
    #1;
    check({tag, " first word"}, {32'd0, storeData}, {32'd0, e0});
    if (lg) begin
      @(negedge clk);
      #1;
      check({tag, " R8 second word"}, {32'd0, storeData}, {32'd0, e1});
    end
    @(negedge clk);
    dataValid = 1'b0;
    #1;
    check({tag, " R9 done"}, {63'd0, done}, 64'd1);
    check({tag, " R7 storeData idle zero"}, {32'd0, storeData}, 64'd0);
    checkReg({tag, " R7 store leaves register"}, dest);
    @(negedge clk);
  endtask

  task automatic testGaps();
    issue(1'b1, 1'b1, 1'b0, 1'b0, 9);
    repeat (2) begin
      @(negedge clk);
      #1;
      check("R12 stall before first word", {63'd0, done}, 64'd0);
    end
    dataValid = 1'b1; busIn = 32'h0BAD_F00D;
    @(negedge clk);
    dataValid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R12 stall between words", {63'd0, done}, 64'd0);
    end
    dataValid = 1'b1; busIn = 32'h7777_1111;
    @(negedge clk);
    dataValid = 1'b0;
    #1;
    check("R12 done after stalled transfer", {63'd0, done}, 64'd1);
    model[9] = {32'h7777_1111, 32'h0BAD_F00D};
    checkReg("R4 R12 stalled little-endian load", 9);
    @(negedge clk);
  endtask

  task automatic testStartIgnored();
    issue(1'b1, 1'b1, 1'b0, 1'b1, 3);
    dataValid = 1'b1; busIn = 32'hAAAA_0001;
    @(negedge clk);
    dataValid = 1'b0;
    start = 1'b1; isLoad = 1'b0; isLong = 1'b0; isFloat = 1'b1; bigEndian = 1'b0;
    instr = {16'h0, 4'd7, 12'h0};
    @(negedge clk);
    start = 1'b0; instr = '0;
    dataValid = 1'b1; busIn = 32'hBBBB_0002;
    @(negedge clk);
    dataValid = 1'b0;
    #1;
    check("R10 done of original transfer", {63'd0, done}, 64'd1);
    start = 1'b1; isLoad = 1'b1; isLong = 1'b0; isFloat = 1'b0;
    instr = {16'h0, 4'd7, 12'h0};
    @(negedge clk);
    start = 1'b0; instr = '0;
    dataValid = 1'b1; busIn = 32'hFFFF_FFFF;
    @(negedge clk);
    dataValid = 1'b0;
    #1;
    check("R10 no transfer from start during done", {63'd0, done}, 64'd0);
    model[3] = {32'hAAAA_0001, 32'hBBBB_0002};
    checkReg("R10 original register and command kept", 3);
    checkReg("R10 ignored start target untouched", 7);
  endtask

  task automatic testIdleStrobe();
    @(negedge clk);
    dataValid = 1'b1; busIn = 32'h5555_AAAA; isLoad = 1'b1;
    repeat (3) @(negedge clk);
    dataValid = 1'b0;
    #1;
    check("R11 no done from idle strobes", {63'd0, done}, 64'd0);
    for (int i = 0; i < 16; i++) checkReg("R11 registers unchanged", i);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testLoad("R3 long big-endian load", 1'b1, 1'b0, 1'b1, 4, 32'h1111_2222, 32'h3333_4444);
    testLoad("R4 long little-endian load", 1'b1, 1'b1, 1'b0, 5, 32'h5555_6666, 32'h7777_8888);
    testLoad("R6 int load negative", 1'b0, 1'b0, 1'b0, 6, 32'h8000_0123, 32'h0);
    testLoad("R5 float load keeps low", 1'b0, 1'b1, 1'b1, 6, 32'h3F80_0000, 32'h0);
    testLoad("R6 int load positive", 1'b0, 1'b0, 1'b1, 15, 32'h7FFF_FFFE, 32'h0);
    testLoad("R5 float load into long", 1'b0, 1'b1, 1'b0, 4, 32'hC2C8_0000, 32'h0);
    testStore("R7 float store", 1'b0, 1'b1, 1'b0, 4);
    testStore("R7 int store", 1'b0, 1'b0, 1'b1, 4);
    testStore("R8 long big-endian store", 1'b1, 1'b0, 1'b1, 5);
    testStore("R8 long little-endian store", 1'b1, 1'b1, 1'b0, 5);
    testGaps();
    testStartIgnored();
    testIdleStrobe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule